// File: doc/BRIEF.md
# Sample ROM Header Validator and Fetcher

This block sits between an ADPCM playback engine and the external ROM that holds its samples. After every reset it reads a five-byte header from the bottom of the ROM. The first byte gives the number of samples in the ROM and is kept in a register. The other four bytes form a fixed signature. If any of those four bytes is wrong, playback stays disabled until the next reset.

Once the header has been accepted, the block serves single-byte reads for the decoder. The ROM is reached through a chip-select and valid handshake. The valid input is ignored in the first cycle after chip-select goes high, and the address is held steady until the byte is taken. On request the block also runs a silence interval: a prescaler divides the clock-enable rate down to a slow tick, and the interval lasts a fixed number of those ticks.

Every register moves only on cycles where the clock enable is high. The reset is synchronous and active-high.

Top module: `smp_rom_fetch`

## Requirements
- R1: While reset is high and on the first cycle after it, rom_cs, hdr_done, sig_err, play_en, rd_busy, rd_done and sil_busy are all 0.
- R2: After reset, before any decoder access, the block issues exactly five ROM accesses with addresses 0, 1, 2, 3 and 4 in ascending order. Only one access is outstanding at a time.
- R3: The byte read from address 0 appears on smp_count once hdr_done is 1.
- R4: If the bytes at addresses 1, 2, 3 and 4 are 0x5A, 0xA5, 0x69 and 0x55, the result is hdr_done=1, play_en=1 and sig_err=0. If any of them differs, the result is sig_err=1 and play_en=0, and both hold until the next reset. A later reset reads the header again.
- R5: rom_ok is ignored in the first clock-enabled cycle after rom_cs rises. With rom_ok held at 1, an access keeps rom_cs high for exactly two cycles and captures the byte present in the second cycle.
- R6: rom_addr does not change while rom_cs is high. rom_cs falls on the first edge after rom_ok is accepted, so an access whose rom_ok arrives after three cycles holds rom_cs for four cycles.
- R7: When play_en is 1 and no access is running (rd_busy=0), rd_req starts a ROM read of rd_addr. The byte at that address appears on rd_data together with a one-cycle rd_done pulse. rd_req is ignored while an access is running or while play_en is 0.
- R8: sil_start with play_en=1 and sil_busy=0 raises sil_busy for exactly TICK_DIV*SIL_TICKS clock-enabled cycles (512 with the default parameters). sil_start is ignored while sil_busy is 1 or while play_en is 0.
- R9: On cycles where cen is 0, no register changes state. Inputs offered only during such cycles have no effect, and the silence interval is stretched by the number of disabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cen | input | 1 | Clock enable; state advances only when high |
| rd_req | input | 1 | Decoder byte-read request |
| rd_addr | input | 18 | Decoder byte address |
| rd_data | output | 8 | Byte returned to the decoder |
| rd_done | output | 1 | One-cycle pulse marking rd_data valid |
| rd_busy | output | 1 | A ROM access is outstanding |
| sil_start | input | 1 | Request a silence interval |
| sil_busy | output | 1 | Silence interval running |
| smp_count | output | 8 | Sample count from header byte 0 |
| hdr_done | output | 1 | Header fetch finished |
| sig_err | output | 1 | Sticky signature mismatch flag |
| play_en | output | 1 | Playback allowed |
| rom_cs | output | 1 | ROM chip select, address valid |
| rom_addr | output | 18 | ROM byte address |
| rom_data | input | 8 | ROM read data |
| rom_ok | input | 1 | ROM data valid |

## Verification
The header fetch is run against three ROM images and two ROM behaviours. One image is correct and is served by a ROM whose valid is always high but whose data lags one cycle. That case can only pass if the first-cycle valid is ignored. The same correct image is then served by a ROM with three cycles of latency, which separates the capture point from the select edge. A third image has one corrupted signature byte, and it shows that the error blocks both reads and silence. Decoder reads use low and high addresses, and a second request issued during an access must be dropped. The silence interval is timed once with the clock enable running freely and once with a stall in the middle, and the two lengths are compared with the expected tick product.

// File: rtl/smp_rom_pkg.sv
package smp_rom_pkg;
  localparam int BYTE_W  = 8;
  localparam int HDR_LEN = 5;
  localparam int IDX_W   = $clog2(HDR_LEN);

  typedef enum logic [1:0] {HS_ISSUE, HS_WAIT, HS_END} hdr_st_t;

  // Expected signature byte for header index 1..4
  function automatic logic [BYTE_W-1:0] sig_byte(input logic [IDX_W-1:0] i);
    case (i)
      IDX_W'(1): sig_byte = 8'h5A;
      IDX_W'(2): sig_byte = 8'hA5;
      IDX_W'(3): sig_byte = 8'h69;
      IDX_W'(4): sig_byte = 8'h55;
      default:   sig_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smp_rom_port.sv
module smp_rom_port
  import smp_rom_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cen,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] data,
  output logic              rom_cs,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [BYTE_W-1:0] rom_data,
  input  logic              rom_ok
);
  logic first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_cs   <= 1'b0;
      rom_addr <= '0;
      first_q  <= 1'b0;
      data     <= '0;
      done     <= 1'b0;
    end else if (cen) begin
      done <= 1'b0;
      if (!rom_cs) begin
        if (go) begin
          rom_cs   <= 1'b1;
          rom_addr <= go_addr;
          first_q  <= 1'b1;
        end
      end else if (first_q) begin
        // valid is not trusted in the first cycle of an access
        first_q <= 1'b0;
      end else if (rom_ok) begin
        data   <= rom_data;
        done   <= 1'b1;
        rom_cs <= 1'b0;
      end
    end
  end

  assign busy = rom_cs;
endmodule

// File: rtl/smp_hdr_seq.sv
module smp_hdr_seq
  import smp_rom_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cen,
  input  logic              port_busy,
  input  logic              port_done,
  input  logic [BYTE_W-1:0] port_data,
  output logic              go,
  output logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] smp_count,
  output logic              hdr_done,
  output logic              sig_err,
  output logic              play_en
);
  hdr_st_t          st;
  logic [IDX_W-1:0] idx;
  logic             mismatch;

  assign mismatch = (idx != '0) && (port_data != sig_byte(idx));
  assign go       = (st == HS_ISSUE) && !port_busy;
  assign addr     = ADDR_W'(idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= HS_ISSUE;
      idx       <= '0;
      smp_count <= '0;
      hdr_done  <= 1'b0;
      sig_err   <= 1'b0;
      play_en   <= 1'b0;
    end else if (cen) begin
      case (st)
        HS_ISSUE: if (!port_busy) st <= HS_WAIT;
        HS_WAIT: if (port_done) begin
          if (idx == '0) smp_count <= port_data;
          if (mismatch)  sig_err   <= 1'b1;
          if (idx == IDX_W'(HDR_LEN-1)) begin
            st       <= HS_END;
            hdr_done <= 1'b1;
            play_en  <= !(sig_err || mismatch);
          end else begin
            idx <= idx + IDX_W'(1);
            st  <= HS_ISSUE;
          end
        end
        default: st <= HS_END;
      endcase
    end
  end
endmodule

// File: rtl/smp_sil_timer.sv
module smp_sil_timer #(
  parameter int TICK_DIV  = 4,
  parameter int SIL_TICKS = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic cen,
  input  logic start,
  output logic busy
);
  localparam int DIV_W = $clog2(TICK_DIV + 1);
  localparam int TK_W  = $clog2(SIL_TICKS + 1);

  logic [DIV_W-1:0] div_q;
  logic [TK_W-1:0]  tk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      div_q <= '0;
      tk_q  <= '0;
    end else if (cen) begin
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          div_q <= '0;
          tk_q  <= '0;
        end
      end else if (div_q == DIV_W'(TICK_DIV-1)) begin
        div_q <= '0;
        if (tk_q == TK_W'(SIL_TICKS-1)) busy <= 1'b0;
        else                            tk_q <= tk_q + TK_W'(1);
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/smp_rom_fetch.sv
module smp_rom_fetch
  import smp_rom_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int TICK_DIV  = 4,
  parameter int SIL_TICKS = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cen,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              rd_done,
  output logic              rd_busy,
  input  logic              sil_start,
  output logic              sil_busy,
  output logic [7:0]        smp_count,
  output logic              hdr_done,
  output logic              sig_err,
  output logic              play_en,
  output logic              rom_cs,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [7:0]        rom_data,
  input  logic              rom_ok
);
  logic              port_busy, port_done, seq_go, dec_go, go;
  logic [BYTE_W-1:0] port_data;
  logic [ADDR_W-1:0] seq_addr, go_addr;

  // header sequencer owns the port until the header is finished
  assign dec_go  = rd_req && play_en && !port_busy;
  assign go      = hdr_done ? dec_go : seq_go;
  assign go_addr = hdr_done ? rd_addr : seq_addr;

  smp_rom_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst), .cen(cen),
    .go(go), .go_addr(go_addr),
    .busy(port_busy), .done(port_done), .data(port_data),
    .rom_cs(rom_cs), .rom_addr(rom_addr),
    .rom_data(rom_data), .rom_ok(rom_ok)
  );

  smp_hdr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .cen(cen),
    .port_busy(port_busy), .port_done(port_done), .port_data(port_data),
    .go(seq_go), .addr(seq_addr),
    .smp_count(smp_count), .hdr_done(hdr_done),
    .sig_err(sig_err), .play_en(play_en)
  );

  smp_sil_timer #(.TICK_DIV(TICK_DIV), .SIL_TICKS(SIL_TICKS)) u_sil (
    .clk(clk), .rst(rst), .cen(cen),
    .start(sil_start && play_en),
    .busy(sil_busy)
  );

  assign rd_data = port_data;
  assign rd_done = port_done && hdr_done;
  assign rd_busy = port_busy;
endmodule

// File: rtl/smp_rom_fetch_chk.sv
module smp_rom_fetch_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              cen,
  input logic              rom_cs,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              hdr_done,
  input logic              sig_err,
  input logic              play_en,
  input logic              rd_done,
  input logic              sil_busy
);
  AST_HDR_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (rom_cs && !hdr_done) |-> (rom_addr < ADDR_W'(5))); // R2

  AST_PLAY_NEEDS_SIG: assert property (@(posedge clk) disable iff (rst)
    play_en |-> (hdr_done && !sig_err)); // R4

  AST_SIG_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    sig_err |=> sig_err); // R4

  AST_FIRST_OK_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cen && rom_cs && !$past(rom_cs)) |=> rom_cs); // R5

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (rom_cs && $past(rom_cs)) |-> (rom_addr == $past(rom_addr))); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (rd_done && cen) |=> !rd_done); // R7

  AST_NO_ACCESS_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (hdr_done && !play_en) |-> !rom_cs); // R7

  AST_CEN_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !cen |=> ($stable(rom_cs) && $stable(sil_busy) && $stable(hdr_done))); // R9
endmodule

bind smp_rom_fetch smp_rom_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cen(cen), .rom_cs(rom_cs), .rom_addr(rom_addr),
  .hdr_done(hdr_done), .sig_err(sig_err), .play_en(play_en),
  .rd_done(rd_done), .sil_busy(sil_busy)
);

// File: tb/smp_rom_fetch_tb.sv
module smp_rom_fetch_tb;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cen = 1'b1;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          rd_done, rd_busy;
  logic          sil_start = 1'b0;
  logic          sil_busy;
  logic [7:0]    smp_count;
  logic          hdr_done, sig_err, play_en;
  logic          rom_cs;
  logic [AW-1:0] rom_addr;
  logic [7:0]    rom_data;
  logic          rom_ok;

  always #5 clk = ~clk;

  smp_rom_fetch u_dut (
    .clk(clk), .rst(rst), .cen(cen),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_done(rd_done), .rd_busy(rd_busy),
    .sil_start(sil_start), .sil_busy(sil_busy),
    .smp_count(smp_count), .hdr_done(hdr_done),
    .sig_err(sig_err), .play_en(play_en),
    .rom_cs(rom_cs), .rom_addr(rom_addr),
    .rom_data(rom_data), .rom_ok(rom_ok)
  );

  // ROM model: data registered one cycle behind the address
  logic [7:0] mem [0:1023];
  logic [7:0] rom_q = 8'h00;
  logic [3:0] lat = '0;
  logic       fast = 1'b1;

  always @(posedge clk) begin
    rom_q <= mem[rom_addr[9:0]];
    if (!rom_cs) lat <= '0;
    else if (lat != 4'hF) lat <= lat + 4'd1;
  end
  assign rom_data = rom_q;
  assign rom_ok   = fast ? 1'b1 : (rom_cs && lat >= 4'd3);

  // access monitor
  int      ncs = 0, cs_hi = 0, stab_err = 0;
  logic [AW-1:0] alog [0:15];
  logic          cs_prev = 1'b0;
  logic [AW-1:0] addr_prev = '0;
  always @(negedge clk) begin
    if (rom_cs && !cs_prev) begin
      if (ncs < 16) alog[ncs] = rom_addr;
      ncs++;
    end
    if (rom_cs && cs_prev && rom_addr != addr_prev) stab_err++;
    if (rom_cs) cs_hi++;
    cs_prev   = rom_cs;
    addr_prev = rom_addr;
  end

  int nchk = 0, nfail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic load_rom(input logic [7:0] b3);
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 3));
    mem[0] = 8'h2C; mem[1] = 8'h5A; mem[2] = 8'hA5; mem[3] = b3; mem[4] = 8'h55;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    ncs = 0; cs_hi = 0; stab_err = 0;
    rst = 1'b0;
  endtask

  task automatic wait_hdr();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (hdr_done) break;
    end
  endtask

  task automatic t_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", {25'd0, rom_cs, hdr_done, sig_err, play_en, rd_busy, rd_done, sil_busy}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first cycle after reset", {29'd0, hdr_done, sig_err, play_en}, 32'd0);
  endtask

  task automatic t_header(input logic fst, input logic [7:0] b3, input logic exp_ok);
    fast = fst;
    load_rom(b3);
    do_reset();
    wait_hdr();
    check("R4 hdr_done", {31'd0, hdr_done}, 32'd1);
    check("R4 play_en", {31'd0, play_en}, {31'd0, exp_ok});
    check("R4 sig_err", {31'd0, sig_err}, {31'd0, !exp_ok});
    check("R3 smp_count", {24'd0, smp_count}, 32'h2C);
    check("R2 header access count", ncs, 5);
    for (int i = 0; i < 5; i++)
      check("R2 header address order", 32'(alog[i]), i);
    check("R6 address stable", stab_err, 0);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input int exp_hi);
    int got = 0;
    @(negedge clk);
    cs_hi = 0;
    rd_addr = a; rd_req = 1'b1;
    @(negedge clk) rd_req = 1'b0;
    for (int i = 0; i < 50; i++) begin
      if (rd_done) begin got = 1; break; end
      @(negedge clk);
    end
    check("R7 rd_done seen", got, 1);
    check("R7 rd_data", {24'd0, rd_data}, {24'd0, mem[a[9:0]]});
    check(fast ? "R5 cs cycles with early valid" : "R6 cs cycles with latency", cs_hi, exp_hi);
    @(negedge clk);
    check("R7 rd_done one cycle", {31'd0, rd_done}, 32'd0);
  endtask

  task automatic t_busy_drop();
    int base;
    @(negedge clk);
    base = ncs;
    rd_addr = 18'h00040; rd_req = 1'b1;
    @(negedge clk) rd_addr = 18'h00077;
    @(negedge clk) rd_req = 1'b0;
    repeat (10) @(negedge clk);
    check("R7 request while busy dropped", ncs - base, 1);
    check("R7 data of first request", {24'd0, rd_data}, {24'd0, mem[10'h040]});
  endtask

  task automatic t_silence(input int stall, input int exp_len);
    int len = 0;
    @(negedge clk) sil_start = 1'b1;
    @(negedge clk) sil_start = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (!sil_busy) break;
      len++;
      if (i == 100) sil_start = 1'b1;
      if (i == 101) sil_start = 1'b0;
      if (i == 200 && stall > 0) cen = 1'b0;
      if (i == 200 + stall) cen = 1'b1;
      @(negedge clk);
    end
    cen = 1'b1;
    check(stall > 0 ? "R9 silence stretched by stall" : "R8 silence length", len, exp_len);
  endtask

  task automatic t_cen_gate();
    int base;
    @(negedge clk);
    base = ncs;
    cen = 1'b0; rd_addr = 18'h00100; rd_req = 1'b1; sil_start = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 no access while cen low", {31'd0, rom_cs}, 32'd0);
    rd_req = 1'b0; sil_start = 1'b0; cen = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 request during cen low had no effect", ncs - base, 0);
    check("R9 silence not started", {31'd0, sil_busy}, 32'd0);
  endtask

  task automatic t_disabled();
    int base;
    @(negedge clk);
    base = ncs;
    rd_addr = 18'h00010; rd_req = 1'b1; sil_start = 1'b1;
    repeat (3) @(negedge clk);
    rd_req = 1'b0; sil_start = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 read ignored when disabled", ncs - base, 0);
    check("R8 silence ignored when disabled", {31'd0, sil_busy}, 32'd0);
    check("R4 error still held", {30'd0, sig_err, play_en}, 32'd2);
  endtask

  initial begin
    load_rom(8'h69);
    t_reset();
    t_header(1'b1, 8'h69, 1'b1);
    t_read(18'h00123, 2);
    t_read(18'h203FF, 2);
    t_busy_drop();
    t_silence(0, 512);
    t_silence(37, 512 + 37);
    t_cen_gate();
    t_header(1'b0, 8'h68, 1'b0);
    t_disabled();
    t_header(1'b0, 8'h69, 1'b1);
    t_read(18'h00255, 4);
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule